// File: doc/BRIEF.md
# PLCP Overhead Alarm and Error Monitor

This block sits behind a PLCP framer that has already found alignment. Once per received frame the framer pulses a frame strobe and presents three overhead values: the received yellow-alarm bit, the 4-bit far-end block error (FEBE) value and a flag saying the locally computed BIP-8 disagreed with the received one. The monitor filters the yellow bit into a stable alarm, sorts each FEBE value into a class, latches sticky error status and keeps two saturating event counters, one for local parity errors and one for errors the far end reports.

Apart from the per-frame fields, the block watches the framer's loss-of-frame level and a one-second tick. When loss of frame lasts across three rising edges of the tick (between two and three seconds), a long-LOF flag rises. It falls again as soon as loss of frame ends.

The frame strobe acts as a valid signal with no ready: the monitor accepts every strobe in the cycle it appears and can never apply back-pressure, so the framer needs no handshake. All other pins are plain levels or single-cycle pulses. Software reads the status and counters and then pulses the read-clear input.

Top module: `plcp_alarm_mon`

## Requirements
- R1: The yellow-alarm output rises in the cycle after the tenth consecutive frame strobe with the yellow bit at 1. Any strobe with the bit at 0 restarts that run.
- R2: Once set, the yellow-alarm output falls in the cycle after the tenth consecutive strobe with the yellow bit at 0. Any strobe with the bit at 1 restarts that run.
- R3: The yellow alarm and its run count change only on frame-strobe cycles. Inputs in cycles without a strobe have no effect on the yellow alarm or on any other status bit or counter.
- R4: A strobed FEBE value from 1 to 8 sets the sticky FEBE-error bit and adds one to the remote-error counter.
- R5: A strobed FEBE value from 9 to 15 sets the sticky invalid-FEBE bit and leaves the remote-error counter unchanged. A value of 0 has no effect on any status bit or counter.
- R6: A strobed FEBE value of 15 also sets the sticky FEBE all-ones bit. That bit is never set unless invalid-FEBE is set too.
- R7: A strobe with the BIP-8 mismatch flag high sets the sticky BIP-8 error bit and adds one to the BIP-8 counter.
- R8: The long-LOF output rises in the cycle after the third rising edge of the one-second tick seen while loss of frame is high. A rising edge is the tick at 1 in a cycle when it was 0 in the previous cycle, and the tick is taken as 0 before reset release. The next cycle after loss of frame goes low clears both the edge count and the long-LOF output.
- R9: Both counters are 16 bits wide and hold at 65535 instead of wrapping.
- R10: A read-clear pulse zeroes the four sticky bits and both counters in the next cycle. If an event arrives in the same cycle, the event wins: its bit ends at 1 and its counter ends at 1.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_stb | input | 1 | One-cycle pulse marking valid overhead fields for one frame |
| yel_rx | input | 1 | Received yellow-alarm bit |
| febe_rx | input | 4 | Received far-end block error value |
| bip_miss | input | 1 | Local BIP-8 mismatch for this frame |
| lof_in | input | 1 | Loss-of-frame state from the framer |
| sec_tick | input | 1 | One-second tick, synchronous to clk |
| rd_clr | input | 1 | Read-clear pulse for sticky bits and counters |
| yel_alarm | output | 1 | Filtered yellow alarm |
| febe_err | output | 1 | Sticky: valid non-zero FEBE seen |
| febe_inv | output | 1 | Sticky: invalid FEBE seen |
| febe_ones | output | 1 | Sticky: FEBE of all ones seen |
| bip_stat | output | 1 | Sticky: BIP-8 mismatch seen |
| lof_long | output | 1 | Loss of frame has persisted for 2 to 3 seconds |
| bip_cnt | output | 16 | Saturating count of local BIP-8 errors |
| rem_cnt | output | 16 | Saturating count of remote error reports |

## Verification
On every cycle the assertions check that the yellow alarm moves only after a strobe carrying the matching bit, that all-ones FEBE implies invalid FEBE, that a zero FEBE sets nothing, that the BIP-8 counter steps by exactly one or holds at its maximum, and that long-LOF drops after loss of frame ends. Only the bench scenarios can show the exact ten-frame run length, the third-tick timing of long-LOF, saturation after 65535 events and the precedence of an event over a same-cycle read-clear. The bench compares every output against a reference model once per cycle.

// File: rtl/plcp_mon_pkg.sv
package plcp_mon_pkg;

  localparam int unsigned FEBE_W = 4;

  typedef enum logic [1:0] {
    FEBE_NONE  = 2'd0,
    FEBE_VALID = 2'd1,
    FEBE_BAD   = 2'd2,
    FEBE_ONES  = 2'd3
  } febe_cls_e;

  // Sort a far-end error value: 0 quiet, 1..8 valid, 9..14 bad, 15 all ones.
  function automatic febe_cls_e febe_classify(input logic [FEBE_W-1:0] v);
    febe_cls_e c;
    if (v == '0)                     c = FEBE_NONE;
    else if (v <= FEBE_W'(8))        c = FEBE_VALID;
    else if (v == {FEBE_W{1'b1}})    c = FEBE_ONES;
    else                             c = FEBE_BAD;
    return c;
  endfunction

  // Sticky status slots handled by the common generate loop in the top.
  localparam int unsigned ST_FEBE_ERR = 0;
  localparam int unsigned ST_FEBE_INV = 1;
  localparam int unsigned ST_FEBE_ONE = 2;
  localparam int unsigned ST_BIP      = 3;
  localparam int unsigned ST_NUM      = 4;

  // Counter slots.
  localparam int unsigned CT_BIP = 0;
  localparam int unsigned CT_REM = 1;
  localparam int unsigned CT_NUM = 2;

endpackage

// File: rtl/plcp_yel_filter.sv
module plcp_yel_filter #(
  parameter int unsigned RUN_LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic bit_in,
  output logic alarm
);
  localparam int unsigned RW = $clog2(RUN_LEN + 1);

  logic [RW-1:0] run_q;
  logic          alarm_q;

  // Count strobed frames that disagree with the current alarm; a run of
  // RUN_LEN disagreements flips it, any agreeing frame restarts the run.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      alarm_q <= 1'b0;
    end else if (stb) begin
      if (bit_in != alarm_q) begin
        if (run_q == RW'(RUN_LEN - 1)) begin
          alarm_q <= bit_in;
          run_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign alarm = alarm_q;
endmodule

// File: rtl/plcp_sat_cnt.sv
module plcp_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] base;

  always_comb begin
    base = clr ? '0 : cnt_q;
    if (inc && base != MAXV) base = base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= base;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/plcp_lof_persist.sv
module plcp_lof_persist #(
  parameter int unsigned TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lof,
  input  logic tick,
  output logic long_lof
);
  localparam int unsigned TW = $clog2(TICKS + 1);

  logic          tick_q;
  logic          edge_seen;
  logic [TW-1:0] n_q;
  logic          long_q;

  assign edge_seen = tick & ~tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      n_q    <= '0;
      long_q <= 1'b0;
    end else begin
      tick_q <= tick;
      if (!lof) begin
        n_q    <= '0;
        long_q <= 1'b0;
      end else if (edge_seen && n_q != TW'(TICKS)) begin
        n_q <= n_q + 1'b1;
        if (n_q == TW'(TICKS - 1)) long_q <= 1'b1;
      end
    end
  end

  assign long_lof = long_q;
endmodule

// File: rtl/plcp_alarm_mon.sv
module plcp_alarm_mon
  import plcp_mon_pkg::*;
#(
  parameter int unsigned YEL_RUN = 10,
  parameter int unsigned LOF_TKS = 3,
  parameter int unsigned CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_stb,
  input  logic              yel_rx,
  input  logic [3:0]        febe_rx,
  input  logic              bip_miss,
  input  logic              lof_in,
  input  logic              sec_tick,
  input  logic              rd_clr,
  output logic              yel_alarm,
  output logic              febe_err,
  output logic              febe_inv,
  output logic              febe_ones,
  output logic              bip_stat,
  output logic              lof_long,
  output logic [CNT_W-1:0]  bip_cnt,
  output logic [CNT_W-1:0]  rem_cnt
);
  febe_cls_e        cls;
  logic [ST_NUM-1:0] st_set;
  logic [ST_NUM-1:0] st_q;
  logic [CT_NUM-1:0] ct_inc;
  logic [CNT_W-1:0]  ct_val [CT_NUM];

  assign cls = febe_classify(febe_rx);

  always_comb begin
    st_set = '0;
    ct_inc = '0;
    if (frm_stb) begin
      st_set[ST_FEBE_ERR] = (cls == FEBE_VALID);
      st_set[ST_FEBE_INV] = (cls == FEBE_BAD) || (cls == FEBE_ONES);
      st_set[ST_FEBE_ONE] = (cls == FEBE_ONES);
      st_set[ST_BIP]      = bip_miss;
      ct_inc[CT_REM]      = (cls == FEBE_VALID);
      ct_inc[CT_BIP]      = bip_miss;
    end
  end

  plcp_yel_filter #(.RUN_LEN(YEL_RUN)) u_yel (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (frm_stb),
    .bit_in (yel_rx),
    .alarm  (yel_alarm)
  );

  plcp_lof_persist #(.TICKS(LOF_TKS)) u_lof (
    .clk      (clk),
    .rst_n    (rst_n),
    .lof      (lof_in),
    .tick     (sec_tick),
    .long_lof (lof_long)
  );

  // Sticky bits: a set in the clear cycle wins over the clear.
  for (genvar i = 0; i < ST_NUM; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rst_n) st_q[i] <= 1'b0;
      else        st_q[i] <= st_set[i] | (st_q[i] & ~rd_clr);
    end
  end

  for (genvar j = 0; j < CT_NUM; j++) begin : g_cnt
    plcp_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ct_inc[j]),
      .clr   (rd_clr),
      .cnt   (ct_val[j])
    );
  end

  assign febe_err  = st_q[ST_FEBE_ERR];
  assign febe_inv  = st_q[ST_FEBE_INV];
  assign febe_ones = st_q[ST_FEBE_ONE];
  assign bip_stat  = st_q[ST_BIP];
  assign bip_cnt   = ct_val[CT_BIP];
  assign rem_cnt   = ct_val[CT_REM];
endmodule

// File: rtl/plcp_alarm_mon_chk.sv
module plcp_alarm_mon_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_stb,
  input logic             yel_rx,
  input logic [3:0]       febe_rx,
  input logic             bip_miss,
  input logic             lof_in,
  input logic             rd_clr,
  input logic             yel_alarm,
  input logic             febe_err,
  input logic             febe_inv,
  input logic             febe_ones,
  input logic             lof_long,
  input logic [CNT_W-1:0] bip_cnt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_yel_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(yel_alarm) |-> $past(frm_stb && yel_rx));

  p_yel_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(yel_alarm) |-> $past(frm_stb && !yel_rx));

  p_yel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_stb |=> $stable(yel_alarm));

  p_febe_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_stb && febe_rx == 4'd0 && !febe_err && !febe_inv) |=> (!febe_err && !febe_inv));

  p_ones_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    febe_ones |-> febe_inv);

  p_bip_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_stb && bip_miss && !rd_clr && bip_cnt != TOP) |=> bip_cnt == $past(bip_cnt) + 1'b1);

  p_lof_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lof_in |=> !lof_long);

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bip_cnt == TOP && !rd_clr) |=> bip_cnt == TOP);
endmodule

bind plcp_alarm_mon plcp_alarm_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_stb   (frm_stb),
  .yel_rx    (yel_rx),
  .febe_rx   (febe_rx),
  .bip_miss  (bip_miss),
  .lof_in    (lof_in),
  .rd_clr    (rd_clr),
  .yel_alarm (yel_alarm),
  .febe_err  (febe_err),
  .febe_inv  (febe_inv),
  .febe_ones (febe_ones),
  .lof_long  (lof_long),
  .bip_cnt   (bip_cnt)
);

// File: tb/plcp_alarm_mon_tb.sv
module plcp_alarm_mon_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_stb = 1'b0, yel_rx = 1'b0, bip_miss = 1'b0;
  logic        lof_in = 1'b0, sec_tick = 1'b0, rd_clr = 1'b0;
  logic [3:0]  febe_rx = 4'd0;
  logic        yel_alarm, febe_err, febe_inv, febe_ones, bip_stat, lof_long;
  logic [15:0] bip_cnt, rem_cnt;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic        m_yel, m_fe, m_inv, m_one, m_bip, m_long, m_secq;
  int          m_run, m_lofn;
  logic [15:0] m_bc, m_rc;

  always #5 clk = ~clk;

  plcp_alarm_mon u_dut (
    .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .yel_rx(yel_rx),
    .febe_rx(febe_rx), .bip_miss(bip_miss), .lof_in(lof_in),
    .sec_tick(sec_tick), .rd_clr(rd_clr), .yel_alarm(yel_alarm),
    .febe_err(febe_err), .febe_inv(febe_inv), .febe_ones(febe_ones),
    .bip_stat(bip_stat), .lof_long(lof_long), .bip_cnt(bip_cnt),
    .rem_cnt(rem_cnt)
  );

  function automatic logic [15:0] sat_next(logic [15:0] c, logic clr, logic inc);
    logic [15:0] b;
    b = clr ? 16'd0 : c;
    if (inc && b != 16'hFFFF) b = b + 16'd1;
    return b;
  endfunction

  task automatic model_reset();
    m_yel = 0; m_fe = 0; m_inv = 0; m_one = 0; m_bip = 0; m_long = 0;
    m_secq = 0; m_run = 0; m_lofn = 0; m_bc = 0; m_rc = 0;
  endtask

  task automatic model_step();
    logic vfe, vinv, vone, vb, edg;
    vfe  = frm_stb && febe_rx >= 4'd1 && febe_rx <= 4'd8;
    vinv = frm_stb && febe_rx >= 4'd9;
    vone = frm_stb && febe_rx == 4'd15;
    vb   = frm_stb && bip_miss;
    if (frm_stb) begin
      if (yel_rx != m_yel) begin
        m_run++;
        if (m_run == 10) begin m_yel = yel_rx; m_run = 0; end
      end else m_run = 0;
    end
    m_fe  = vfe  | (m_fe  & ~rd_clr);
    m_inv = vinv | (m_inv & ~rd_clr);
    m_one = vone | (m_one & ~rd_clr);
    m_bip = vb   | (m_bip & ~rd_clr);
    m_bc  = sat_next(m_bc, rd_clr, vb);
    m_rc  = sat_next(m_rc, rd_clr, vfe);
    edg = sec_tick && !m_secq;
    m_secq = sec_tick;
    if (!lof_in) begin m_lofn = 0; m_long = 0; end
    else if (edg && m_lofn < 3) begin
      m_lofn++;
      if (m_lofn == 3) m_long = 1;
    end
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1/R2/R3 yel_alarm", {15'd0, yel_alarm}, {15'd0, m_yel});
    chk("R4 febe_err", {15'd0, febe_err}, {15'd0, m_fe});
    chk("R5 febe_inv", {15'd0, febe_inv}, {15'd0, m_inv});
    chk("R6 febe_ones", {15'd0, febe_ones}, {15'd0, m_one});
    chk("R7 bip_stat", {15'd0, bip_stat}, {15'd0, m_bip});
    chk("R8 lof_long", {15'd0, lof_long}, {15'd0, m_long});
    chk("R7/R9/R10 bip_cnt", bip_cnt, m_bc);
    chk("R4/R9/R10 rem_cnt", rem_cnt, m_rc);
  endtask

  // One cycle: drive at negedge, update model, sample at following negedge.
  task automatic cyc(logic stb, logic yb, logic [3:0] fv, logic bm,
                     logic lof, logic tk, logic clr);
    frm_stb = stb; yel_rx = yb; febe_rx = fv; bip_miss = bm;
    lof_in = lof; sec_tick = tk; rd_clr = clr;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11 reset yel", {15'd0, yel_alarm}, 16'd0);
    chk("R11 reset cnt", bip_cnt | rem_cnt, 16'd0);
    chk("R11 reset flags", {10'd0, febe_err, febe_inv, febe_ones, bip_stat, lof_long, yel_alarm}, 16'd0);

    // R1: nine ones, a zero restarts, then ten ones set (with idle gaps, R3)
    repeat (9) cyc(1, 1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R1 no set after broken run", {15'd0, yel_alarm}, 16'd0);
    for (int i = 0; i < 10; i++) begin
      cyc(1, 1, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0);   // R3: non-strobe zero ignored
    end
    chk("R1 set after ten ones", {15'd0, yel_alarm}, 16'd1);
    // R2: ten zeros clear
    repeat (9) cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R2 still set after nine zeros", {15'd0, yel_alarm}, 16'd1);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R2 cleared after ten zeros", {15'd0, yel_alarm}, 16'd0);

    // R5: zero FEBE, and unstrobed values, do nothing
    cyc(1, 0, 4'd0, 0, 0, 0, 0);
    cyc(0, 0, 4'd3, 1, 0, 0, 0);
    chk("R5 zero/unstrobed no count", rem_cnt | bip_cnt, 16'd0);
    // R4, R5, R6 each value
    for (int v = 1; v < 16; v++) begin
      cyc(1, 0, 4'(v), 0, 0, 0, 1);
      chk("R4 febe_err per value", {15'd0, febe_err}, {15'd0, (v <= 8)});
      chk("R6 febe_ones per value", {15'd0, febe_ones}, {15'd0, (v == 15)});
    end
    // R10: clear with simultaneous event
    cyc(1, 0, 4'd2, 1, 0, 0, 0);
    cyc(1, 0, 4'd2, 1, 0, 0, 1);
    chk("R10 event wins rem_cnt", rem_cnt, 16'd1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R10 clear bip_cnt", bip_cnt, 16'd0);

    // R8: three tick edges under LOF; held tick is one edge
    cyc(0, 0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R8 not yet after two edges", {15'd0, lof_long}, 16'd0);
    cyc(0, 0, 0, 0, 1, 1, 0);
    chk("R8 set on third edge", {15'd0, lof_long}, 16'd1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R8 cleared when LOF drops", {15'd0, lof_long}, 16'd0);
    cyc(0, 0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 1, 0);
    chk("R8 count restarted", {15'd0, lof_long}, 16'd0);
    cyc(0, 0, 0, 0, 0, 0, 0);

    // R9: saturation of both counters
    for (int i = 0; i < 65540; i++) cyc(1, 0, 4'd5, 1, 0, 0, 0);
    chk("R9 bip_cnt saturated", bip_cnt, 16'hFFFF);
    chk("R9 rem_cnt saturated", rem_cnt, 16'hFFFF);
    cyc(0, 0, 0, 0, 0, 0, 1);

    // Random mix
    begin
      logic yb, lof;
      yb = 0; lof = 0;
      for (int i = 0; i < 6000; i++) begin
        logic [3:0] fv;
        if ($urandom_range(0, 7) == 0) yb = ~yb;
        if ($urandom_range(0, 40) == 0) lof = ~lof;
        fv = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : 4'd0;
        cyc($urandom_range(0, 2) != 0, yb, fv, $urandom_range(0, 9) == 0,
            lof, $urandom_range(0, 3) == 0, $urandom_range(0, 60) == 0);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule